// File: doc/BRIEF.md
# Quad-Channel Serial DAC Write Controller

This controller sits on the host side of a four-channel, 8-bit serial DAC and produces the four control pins it needs: a serial clock, a data line, a word-latch strobe and an output-update strobe. The host hands it one request at a time on a valid/ready interface. Each request carries a 2-bit channel index, a range bit, an 8-bit code and a commit flag. The controller turns the request into an 11-bit serial command, shifts it out MSB first, and then drops the latch strobe to move the word into the selected channel.

The block runs in one of two modes, chosen by a parameter. In deferred mode the update strobe idles high. Words land in holding latches, and a request whose commit flag is set is followed by a low pulse on the update strobe, so every channel changes together. A typical use writes four channels and sets the commit flag only on the last write. In immediate mode the update strobe stays low, so each latch pulse updates its channel at once, and the commit flag has no effect.

Every pin timing is a whole number of system clock cycles. The counts are worked out at elaboration from the system clock period and from the nanosecond limits given as parameters: serial clock period, data setup, latch setup and width, update setup and width.

Top module: `quad_dac_writer`

## Requirements
- R1: After reset the serial clock, the latch strobe and ready are high. The update strobe is high in deferred mode and low in immediate mode.
- R2: Each accepted request produces exactly 11 falling serial-clock edges before the latch strobe falls. On those edges the data line carries, in order: channel bit 1, channel bit 0, the range bit, then code bits 7 down to 0.
- R3: Every high phase and every low phase of the serial clock lasts at least half the configured serial clock period, which is 500 ns by default.
- R4: The data line changes only while the serial clock is high. It is settled at least 50 ns before each falling edge and does not move while the clock is low.
- R5: The latch strobe stays high while bits are shifted. It falls at least 50 ns after the 11th falling edge and stays low for at least 250 ns.
- R6: In deferred mode, a request with its commit flag set is followed by one low pulse on the update strobe. The pulse starts at least 50 ns after the latch strobe rises and lasts at least 250 ns. The update strobe is never low while the latch strobe is low.
- R7: In deferred mode, a request with its commit flag clear leaves the update strobe high for its whole transaction.
- R8: In immediate mode the update strobe is held low at all times, whatever the commit flag.
- R9: A request is taken only when valid and ready are both high, and each one yields exactly one frame. Ready drops after acceptance and returns only when the last strobe is finished. While ready is high, the serial clock and latch strobe are high and the update strobe sits at its idle level.
- R10: Back-to-back requests, including a batch of four deferred writes closed by a commit, each produce a correct, separate frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqChan | input | 2 | Target channel index |
| reqRange | input | 1 | Output range select bit |
| reqCode | input | 8 | Output code |
| reqCommit | input | 1 | Pulse the update strobe after this word (deferred mode only) |
| dacClk | output | 1 | Serial clock; the DAC samples data on its falling edge |
| dacData | output | 1 | Serial data, MSB first |
| dacLoad | output | 1 | Active-low word latch strobe |
| dacLdac | output | 1 | Active-low output update strobe |

## Verification
A control state that is out of step with the shift register shows up as a wrong bit count when the latch strobe falls, or as a wrong decoded word when it rises. Either way the error is visible within one frame, about 560 system cycles by default. A phase counter that reloads badly shows up on the next serial clock edge, as a phase or a setup window that is too short. A lost or stray commit flag shows up on the update strobe within a few dozen cycles after the latch strobe rises, and at the latest before ready returns.

// File: rtl/qdw_pkg.sv
`timescale 1ns/1ps
package qdw_pkg;

  localparam int FRAME_BITS = 11;

  // Serial command word, shifted out MSB first.
  typedef struct packed {
    logic [1:0] chan;
    logic       rng;
    logic [7:0] code;
  } qdw_word_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HI,
    ST_LO,
    ST_LOAD,
    ST_GAP,
    ST_LDAC
  } qdw_state_e;

  // Control -> datapath strobes and pin levels for the coming cycle.
  typedef struct packed {
    logic capture;
    logic shift;
    logic clkLvl;
    logic loadLvl;
    logic ldacLvl;
  } qdw_strobe_t;

  function automatic int maxI(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int nsToCycles(int ns, int periodNs);
    return maxI(1, (ns + periodNs - 1) / periodNs);
  endfunction

endpackage

// File: rtl/qdw_ctrl.sv
`timescale 1ns/1ps
module qdw_ctrl
  import qdw_pkg::*;
#(
  parameter int HALF_CYC   = 25,
  parameter int LOADW_CYC  = 13,
  parameter int GAP_CYC    = 3,
  parameter int LDACW_CYC  = 13,
  parameter bit LDAC_DEFER = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqCommit,
  output logic        reqReady,
  output qdw_strobe_t strobe
);

  localparam int MAX_CYC = maxI(maxI(HALF_CYC, LOADW_CYC), maxI(GAP_CYC, LDACW_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int BIT_W   = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] LOADW_LD = CNT_W'(LOADW_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] LDACW_LD = CNT_W'(LDACW_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  qdw_state_e       state, nextState;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [BIT_W-1:0] bitIdx;
  logic             commitQ;
  logic             phaseDone;
  logic             doCapture, doShift;

  assign phaseDone = (cnt == '0);
  assign reqReady  = (state == ST_IDLE);

  always_comb begin
    nextState = state;
    cntNext   = phaseDone ? cnt : cnt - 1'b1;
    doCapture = 1'b0;
    doShift   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          nextState = ST_HI;
          cntNext   = HALF_LD;
          doCapture = 1'b1;
        end
      end
      ST_HI: begin
        if (phaseDone) begin
          nextState = ST_LO;
          cntNext   = HALF_LD;
        end
      end
      ST_LO: begin
        if (phaseDone) begin
          if (bitIdx == LAST_BIT) begin
            nextState = ST_LOAD;
            cntNext   = LOADW_LD;
          end else begin
            nextState = ST_HI;
            cntNext   = HALF_LD;
            doShift   = 1'b1;
          end
        end
      end
      ST_LOAD: begin
        if (phaseDone) begin
          if (commitQ && LDAC_DEFER) begin
            nextState = ST_GAP;
            cntNext   = GAP_LD;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      ST_GAP: begin
        if (phaseDone) begin
          nextState = ST_LDAC;
          cntNext   = LDACW_LD;
        end
      end
      ST_LDAC: begin
        if (phaseDone) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // Pin levels follow the next state so the registered pins match the current state.
  always_comb begin
    strobe.capture = doCapture;
    strobe.shift   = doShift;
    strobe.clkLvl  = (nextState != ST_LO);
    strobe.loadLvl = (nextState != ST_LOAD);
    strobe.ldacLvl = LDAC_DEFER ? (nextState != ST_LDAC) : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bitIdx  <= '0;
      commitQ <= 1'b0;
    end else begin
      state <= nextState;
      cnt   <= cntNext;
      if (doCapture) begin
        bitIdx  <= '0;
        commitQ <= reqCommit;
      end else if (doShift) begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && $past(state) == ST_LO) |-> ($past(bitIdx) == LAST_BIT));

  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && cnt != '0) |=> (state == $past(state)));

  // R7
  gap_needs_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |-> commitQ);

endmodule

// File: rtl/qdw_datapath.sv
`timescale 1ns/1ps
module qdw_datapath
  import qdw_pkg::*;
#(
  parameter bit LDAC_IDLE = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  qdw_strobe_t strobe,
  input  qdw_word_t   reqWord,
  output logic        dacClk,
  output logic        dacData,
  output logic        dacLoad,
  output logic        dacLdac
);

  logic [FRAME_BITS-1:0] shiftQ;
  logic clkQ, loadQ, ldacQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      clkQ   <= 1'b1;
      loadQ  <= 1'b1;
      ldacQ  <= LDAC_IDLE;
    end else begin
      if (strobe.capture)    shiftQ <= reqWord;
      else if (strobe.shift) shiftQ <= {shiftQ[FRAME_BITS-2:0], 1'b0};
      clkQ  <= strobe.clkLvl;
      loadQ <= strobe.loadLvl;
      ldacQ <= strobe.ldacLvl;
    end
  end

  assign dacClk  = clkQ;
  assign dacData = shiftQ[FRAME_BITS-1];
  assign dacLoad = loadQ;
  assign dacLdac = ldacQ;

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkQ && !$past(clkQ)) |-> $stable(dacData));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadQ |-> (ldacQ == LDAC_IDLE));

  // R5
  load_clk_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadQ |-> clkQ);

endmodule

// File: rtl/quad_dac_writer.sv
`timescale 1ns/1ps
module quad_dac_writer
  import qdw_pkg::*;
#(
  parameter int SYS_CLK_NS     = 20,
  parameter int SCLK_PERIOD_NS = 1000,
  parameter int DATA_SETUP_NS  = 50,
  parameter int LOAD_SETUP_NS  = 50,
  parameter int LOAD_WIDTH_NS  = 250,
  parameter int LDAC_SETUP_NS  = 50,
  parameter int LDAC_WIDTH_NS  = 250,
  parameter bit DEFER_MODE     = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic [1:0] reqChan,
  input  logic       reqRange,
  input  logic [7:0] reqCode,
  input  logic       reqCommit,
  output logic       dacClk,
  output logic       dacData,
  output logic       dacLoad,
  output logic       dacLdac
);

  localparam int HALF_CYC  = maxI(nsToCycles((SCLK_PERIOD_NS + 1) / 2, SYS_CLK_NS),
                                  maxI(nsToCycles(DATA_SETUP_NS, SYS_CLK_NS),
                                       nsToCycles(LOAD_SETUP_NS, SYS_CLK_NS)));
  localparam int LOADW_CYC = nsToCycles(LOAD_WIDTH_NS, SYS_CLK_NS);
  localparam int GAP_CYC   = nsToCycles(LDAC_SETUP_NS, SYS_CLK_NS);
  localparam int LDACW_CYC = nsToCycles(LDAC_WIDTH_NS, SYS_CLK_NS);

  qdw_strobe_t strobe;
  qdw_word_t   reqWord;

  assign reqWord = '{chan: reqChan, rng: reqRange, code: reqCode};

  qdw_ctrl #(
    .HALF_CYC  (HALF_CYC),
    .LOADW_CYC (LOADW_CYC),
    .GAP_CYC   (GAP_CYC),
    .LDACW_CYC (LDACW_CYC),
    .LDAC_DEFER(DEFER_MODE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqCommit(reqCommit),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  qdw_datapath #(
    .LDAC_IDLE(DEFER_MODE)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .reqWord(reqWord),
    .dacClk (dacClk),
    .dacData(dacData),
    .dacLoad(dacLoad),
    .dacLdac(dacLdac)
  );

  // R9
  ready_idle_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (dacClk && dacLoad && (dacLdac == DEFER_MODE)));

  // R8
  generate
    if (!DEFER_MODE) begin : g_imm
      imm_ldac_low_chk: assert property (@(posedge clk) disable iff (!rstN)
        reqReady |=> !dacLdac);
    end
  endgenerate

endmodule

// File: tb/quad_dac_writer_bench.sv
`timescale 1ns/1ps
module quad_dac_writer_bench;

  localparam int CLK_NS   = 20;
  localparam int HALF_NS  = 500;
  localparam int SETUP_NS = 50;
  localparam int WIDTH_NS = 250;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic       sel = 1'b0;   // 0: deferred instance, 1: immediate instance
  logic       reqValid = 1'b0;
  logic [1:0] reqChan = '0;
  logic       reqRange = 1'b0;
  logic [7:0] reqCode = '0;
  logic       reqCommit = 1'b0;

  logic dReady, dClk, dData, dLoad, dLdac;
  logic iReady, iClk, iData, iLoad, iLdac;

  quad_dac_writer u_quad_dac_writer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid && !sel), .reqReady(dReady),
    .reqChan(reqChan), .reqRange(reqRange), .reqCode(reqCode), .reqCommit(reqCommit),
    .dacClk(dClk), .dacData(dData), .dacLoad(dLoad), .dacLdac(dLdac));

  quad_dac_writer #(.DEFER_MODE(1'b0)) u_imm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid && sel), .reqReady(iReady),
    .reqChan(reqChan), .reqRange(reqRange), .reqCode(reqCode), .reqCommit(reqCommit),
    .dacClk(iClk), .dacData(iData), .dacLoad(iLoad), .dacLdac(iLdac));

  logic mReady, mClk, mData, mLoad, mLdac;
  assign mReady = sel ? iReady : dReady;
  assign mClk   = sel ? iClk   : dClk;
  assign mData  = sel ? iData  : dData;
  assign mLoad  = sel ? iLoad  : dLoad;
  assign mLdac  = sel ? iLdac  : dLdac;

  typedef struct {
    logic [10:0] word;
    bit          commit;
  } exp_t;
  exp_t expQ[$];

  int nChecks = 0, nFails = 0;
  int pushed = 0, framesSeen = 0, commitsExp = 0, ldacSeen = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: hold the request until it is accepted, then record it.
  task automatic send(logic [1:0] ch, logic rg, logic [7:0] cd, logic cm);
    exp_t e;
    @(negedge clk);
    reqValid = 1'b1; reqChan = ch; reqRange = rg; reqCode = cd; reqCommit = cm;
    while (!mReady) @(negedge clk);
    @(posedge clk);
    e.word = {ch, rg, cd};
    e.commit = cm;
    expQ.push_back(e);
    pushed++;
    if (cm && !sel) commitsExp++;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!mReady) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  // Monitor: decode the pin protocol and check timing.
  logic prevClk, prevData, prevLoad, prevLdac, prevReady;
  int sinceData, sinceFall, sinceLoadFall, sinceLoadRise, sinceLdacFall, phaseCyc, bits;
  logic [10:0] word;
  bit expectLdac, ldacFell, lastCommit;

  always @(negedge clk) begin
    if (!rstN) begin
      prevClk = 1'b1; prevData = 1'b0; prevLoad = 1'b1; prevLdac = 1'b1; prevReady = 1'b1;
      sinceData = 1000; sinceFall = 1000; sinceLoadFall = 0; sinceLoadRise = 1000;
      sinceLdacFall = 0; phaseCyc = 1000; bits = 0; word = '0;
      expectLdac = 0; ldacFell = 0; lastCommit = 0;
    end else begin
      sinceData++; sinceFall++; sinceLoadFall++; sinceLoadRise++; sinceLdacFall++; phaseCyc++;
      if (mData != prevData) begin
        sinceData = 0;
        if (!mClk && !prevClk) chk(0, "R4", "DATA moved while CLK low", mData, prevData);
      end
      if (mClk != prevClk) begin
        chk(phaseCyc * CLK_NS >= HALF_NS, "R3", "CLK phase ns", phaseCyc * CLK_NS, HALF_NS);
        phaseCyc = 0;
      end
      if (prevClk && !mClk) begin
        chk(sinceData * CLK_NS >= SETUP_NS, "R4", "DATA setup ns", sinceData * CLK_NS, SETUP_NS);
        chk(mLoad == 1'b1, "R5", "LOAD high while shifting", mLoad, 1);
        word = {word[9:0], prevData};
        bits++;
        sinceFall = 0;
      end
      if (prevLoad && !mLoad) begin
        chk(bits == 11, "R2", "falling edges before LOAD", bits, 11);
        chk(sinceFall * CLK_NS >= SETUP_NS, "R5", "LOAD setup ns", sinceFall * CLK_NS, SETUP_NS);
        if (!sel) chk(mLdac == 1'b1, "R6", "LDAC high while LOAD low", mLdac, 1);
        else      chk(mLdac == 1'b0, "R8", "LDAC low in immediate mode", mLdac, 0);
        sinceLoadFall = 0;
      end
      if (!prevLoad && mLoad) begin
        chk(sinceLoadFall * CLK_NS >= WIDTH_NS, "R5", "LOAD width ns", sinceLoadFall * CLK_NS, WIDTH_NS);
        if (expQ.size() == 0) begin
          chk(0, "R9", "frame with no accepted request", framesSeen, pushed);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          chk(word == e.word, "R2", "decoded word", int'(word), int'(e.word));
          lastCommit = e.commit;
          expectLdac = e.commit && !sel;
        end
        framesSeen++;
        bits = 0;
        sinceLoadRise = 0;
      end
      if (!sel) begin
        if (prevLdac && !mLdac) begin
          chk(expectLdac, "R7", "LDAC pulse without commit", 1, 0);
          chk(sinceLoadRise * CLK_NS >= SETUP_NS, "R6", "LDAC setup ns", sinceLoadRise * CLK_NS, SETUP_NS);
          chk(mLoad == 1'b1, "R6", "LOAD high at LDAC fall", mLoad, 1);
          sinceLdacFall = 0;
          ldacFell = 1;
        end
        if (!prevLdac && mLdac) begin
          chk(sinceLdacFall * CLK_NS >= WIDTH_NS, "R6", "LDAC width ns", sinceLdacFall * CLK_NS, WIDTH_NS);
          expectLdac = 0;
          ldacSeen++;
        end
      end else if (mLdac) begin
        chk(0, "R8", "LDAC high in immediate mode", 1, 0);
      end
      if (mReady && !prevReady) begin
        chk(mClk && mLoad && (mLdac == !sel), "R9", "pins idle when ready",
            {mClk, mLoad, mLdac}, {2'b11, !sel});
        if (!sel) begin
          chk(!expectLdac, "R6", "commit pulse done before ready", expectLdac, 0);
          if (!lastCommit) chk(!ldacFell, "R7", "LDAC stayed high without commit", ldacFell, 0);
        end
        ldacFell = 0;
      end
      prevClk = mClk; prevData = mData; prevLoad = mLoad; prevLdac = mLdac; prevReady = mReady;
    end
  end

  initial begin
    #(CLK_NS * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", framesSeen, pushed);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state of both instances
    chk(dClk && dLoad, "R1", "deferred CLK/LOAD idle high", {dClk, dLoad}, 3);
    chk(dLdac == 1'b1, "R1", "deferred LDAC idle high", dLdac, 1);
    chk(dReady == 1'b1, "R1", "deferred ready", dReady, 1);
    chk(iClk && iLoad && iReady, "R1", "immediate CLK/LOAD/ready high", {iClk, iLoad, iReady}, 7);
    chk(iLdac == 1'b0, "R1", "immediate LDAC idle low", iLdac, 0);

    // R10 batch of four deferred writes closed by a commit
    send(2'd0, 1'b0, 8'hA5, 1'b0);
    send(2'd1, 1'b1, 8'h3C, 1'b0);
    send(2'd2, 1'b0, 8'hFF, 1'b0);
    send(2'd3, 1'b1, 8'h00, 1'b1);
    // R6 single committed write, R7 uncommitted write
    send(2'd2, 1'b1, 8'h81, 1'b1);
    send(2'd1, 1'b0, 8'h5A, 1'b0);
    waitIdle();

    // R8 immediate mode ignores the commit flag
    sel = 1'b1;
    repeat (3) @(negedge clk);
    send(2'd3, 1'b0, 8'hC3, 1'b1);
    send(2'd0, 1'b1, 8'h7E, 1'b0);
    waitIdle();

    // R9 one frame per accepted request; R6 one LDAC pulse per commit
    chk(expQ.size() == 0, "R9", "requests left without a frame", expQ.size(), 0);
    chk(framesSeen == pushed, "R9", "frames vs accepted requests", framesSeen, pushed);
    chk(ldacSeen == commitsExp, "R6", "LDAC pulses vs commits", ldacSeen, commitsExp);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule